// File: doc/BRIEF.md
# SPI Flash Page-Program Splitter

This block turns one write request into a series of serial-flash program operations. A request gives a start address and a byte count, and the payload arrives on a separate byte stream with a valid/ready handshake. The device accepts at most one page (256 bytes) per program command, so the block cuts the payload into chunks that end at page boundaries. The first chunk is sized by where the start address sits inside its page. Every later chunk is a full page, except possibly the last.

For each chunk the block sends three framed commands to a byte-level serializer, each inside its own chip-select window. First it reads the device status, again and again until the busy flag is clear. Then it sends a write-enable. Then it sends the program command with the chunk's address and data. The serializer takes one byte per `spi_tx_valid`/`spi_tx_ready` handshake and returns the byte received in the same handshake on `spi_rx_byte`. When the last chunk has been sent, `done` pulses and `written` holds the number of payload bytes.

An empty request completes at once. A request that would run past the end of the device is refused with no bus traffic.

Top module: `spf_page_writer`

## Requirements
- R1: No program frame carries data past the end of a 256-byte page. The first chunk is the smaller of the length and 256 minus (start address mod 256). Each later chunk is the smaller of 256 and the bytes still left.
- R2: A program frame is byte 0x02, then the chunk start address in 3 bytes with the most significant byte first, then the chunk's payload bytes in stream order.
- R3: Before every chunk the block sends status-read frames, each being byte 0x05 followed by one dummy byte. It repeats them while bit 0 of the byte returned with the dummy byte is 1. Once that bit is 0 it sends a frame holding only 0x06. Other status bits have no effect.
- R4: `spi_cs_n` is low for the whole of a frame and high for at least one cycle between frames. `spi_tx_valid` is never high while `spi_cs_n` is high.
- R5: `in_ready` is high only during the data part of a program frame. Payload bytes offered at any other time are not consumed.
- R6: A request with length 0, at any address, gives a `done` pulse in the cycle after acceptance with `rejected` low and `written` 0, and causes no bus traffic.
- R7: A nonzero request whose start plus length exceeds DEV_BYTES gives `done` together with `rejected` in the cycle after acceptance, and causes no bus traffic. A request ending exactly at DEV_BYTES is accepted.
- R8: `written` is cleared on acceptance. It grows by each chunk's payload length only when that chunk's frame ends, counts no command or address bytes, and equals the request length at `done`.
- R9: `req_ready` is high only when no request is in progress. `done` is a single-cycle pulse in the cycle after the last program frame's select is released.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Write request offered |
| req_ready | output | 1 | Block idle, request taken when valid |
| req_addr | input | ADDR_W | Start byte address |
| req_len | input | LEN_W | Byte count |
| in_valid | input | 1 | Payload byte offered |
| in_ready | output | 1 | Payload byte taken when valid |
| in_data | input | 8 | Payload byte |
| spi_cs_n | output | 1 | Device select, active low |
| spi_tx_valid | output | 1 | Byte offered to the serializer |
| spi_tx_ready | input | 1 | Serializer takes the byte |
| spi_tx_byte | output | 8 | Byte to shift out |
| spi_rx_byte | input | 8 | Byte shifted in during the same handshake |
| done | output | 1 | Request finished (pulse) |
| rejected | output | 1 | Request refused, valid with done |
| written | output | LEN_W | Payload bytes programmed so far |

## Verification
The bench targets writes that start one byte before a page end, that start exactly on a page boundary, and that cover three pages with both ends ragged. A splitter with an off-by-one in its first-chunk size would give a frame one byte too long or too short, or an address byte that is off by one. The device model reports busy for several polls, with unrelated status bits set, so a design that skips polling or decodes the wrong bit sends write-enable too early. The payload stream stays valid between frames, so a design that leaks `in_ready` outside the data phase drops or shifts bytes. An empty request aimed beyond the device, and requests ending exactly at and one byte past the device end, expose a size check done in the wrong order or with the wrong comparison.

// File: rtl/spf_pkg.sv
package spf_pkg;

  typedef enum logic [3:0] {
    ST_IDLE,
    ST_POLL_OP,
    ST_POLL_RD,
    ST_POLL_GAP,
    ST_WEN_OP,
    ST_WEN_GAP,
    ST_PRG_OP,
    ST_PRG_ADR,
    ST_PRG_DAT,
    ST_PRG_GAP
  } spf_state_e;

  localparam logic [7:0] OP_STATUS = 8'h05;
  localparam logic [7:0] OP_WEN    = 8'h06;
  localparam logic [7:0] OP_PROG   = 8'h02;
  localparam logic [7:0] DUMMY     = 8'h00;
  localparam int         BUSY_BIT  = 0;

endpackage

// File: rtl/spf_chunk_calc.sv
module spf_chunk_calc #(
  parameter int ADDR_W = 24,
  parameter int LEN_W  = 17,
  parameter int PAGE_W = 8
) (
  input  logic [ADDR_W-1:0] cur_addr,
  input  logic [LEN_W-1:0]  remain,
  output logic [PAGE_W:0]   chunk
);

  localparam int CH_W = PAGE_W + 1;
  localparam logic [CH_W-1:0] PAGE_SZ = CH_W'(1) << PAGE_W;

  logic [CH_W-1:0]  room;
  logic [LEN_W-1:0] room_ext;

  // bytes from the current address to the end of its page
  assign room     = PAGE_SZ - {1'b0, cur_addr[PAGE_W-1:0]};
  assign room_ext = LEN_W'(room);
  assign chunk    = (remain < room_ext) ? CH_W'(remain) : room;

endmodule

// File: rtl/spf_req_check.sv
module spf_req_check #(
  parameter int              ADDR_W    = 24,
  parameter int              LEN_W     = 17,
  parameter longint unsigned DEV_BYTES = 64'd1048576
) (
  input  logic [ADDR_W-1:0] addr,
  input  logic [LEN_W-1:0]  len,
  output logic              is_zero,
  output logic              is_over
);

  localparam int SUM_W = ((ADDR_W > LEN_W) ? ADDR_W : LEN_W) + 1;
  localparam logic [SUM_W-1:0] LIMIT = SUM_W'(DEV_BYTES);

  logic [SUM_W-1:0] req_end;

  assign req_end = SUM_W'(addr) + SUM_W'(len);
  assign is_zero = (len == '0);
  assign is_over = (req_end > LIMIT);

endmodule

// File: rtl/spf_track.sv
module spf_track #(
  parameter int ADDR_W = 24,
  parameter int LEN_W  = 17,
  parameter int PAGE_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load,
  input  logic [ADDR_W-1:0] load_addr,
  input  logic [LEN_W-1:0]  load_len,
  input  logic              clr_written,
  input  logic              chunk_load,
  input  logic              byte_fire,
  input  logic              chunk_close,
  output logic [ADDR_W-1:0] cur_addr,
  output logic              last_in_chunk,
  output logic              all_done,
  output logic [LEN_W-1:0]  written
);

  localparam int CH_W = PAGE_W + 1;

  logic [ADDR_W-1:0] addr_q, addr_d;
  logic [LEN_W-1:0]  rem_q, rem_d;
  logic [CH_W-1:0]   clen_q, cleft_q, cleft_d;
  logic [LEN_W-1:0]  wr_q, wr_d;
  logic [CH_W-1:0]   chunk_nxt;
  logic              addr_en, rem_en, clen_en, cleft_en, wr_en;

  spf_chunk_calc #(
    .ADDR_W (ADDR_W),
    .LEN_W  (LEN_W),
    .PAGE_W (PAGE_W)
  ) u_calc (
    .cur_addr (addr_q),
    .remain   (rem_q),
    .chunk    (chunk_nxt)
  );

  // clock enables
  assign addr_en  = load | byte_fire;
  assign rem_en   = load | byte_fire;
  assign clen_en  = chunk_load;
  assign cleft_en = chunk_load | byte_fire;
  assign wr_en    = clr_written | chunk_close;

  always_comb begin
    addr_d  = byte_fire ? addr_q + ADDR_W'(1) : load_addr;
    rem_d   = byte_fire ? rem_q - LEN_W'(1) : load_len;
    cleft_d = byte_fire ? cleft_q - CH_W'(1) : chunk_nxt;
    wr_d    = clr_written ? '0 : wr_q + LEN_W'(clen_q);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      addr_q  <= '0;
      rem_q   <= '0;
      clen_q  <= '0;
      cleft_q <= '0;
      wr_q    <= '0;
    end else begin
      if (addr_en)  addr_q  <= addr_d;
      if (rem_en)   rem_q   <= rem_d;
      if (clen_en)  clen_q  <= chunk_nxt;
      if (cleft_en) cleft_q <= cleft_d;
      if (wr_en)    wr_q    <= wr_d;
    end
  end

  assign cur_addr      = addr_q;
  assign last_in_chunk = (cleft_q == CH_W'(1));
  assign all_done      = (rem_q == '0);
  assign written       = wr_q;

  // R1: a chunk is never empty and never longer than what is left
  assert_chunk_fits_R1: assert property (@(posedge clk) disable iff (!rst_n)
    chunk_load |-> (chunk_nxt != '0) && (LEN_W'(chunk_nxt) <= rem_q))
    else $error("chunk size out of range");

  // R8: the count moves only on acceptance or at the end of a chunk
  assert_written_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !(chunk_close || clr_written) |=> $stable(wr_q))
    else $error("written changed outside a chunk end");

endmodule

// File: rtl/spf_seq.sv
module spf_seq
  import spf_pkg::*;
#(
  parameter int ADDR_W = 24,
  parameter int PAGE_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  input  logic              req_zero,
  input  logic              req_over,
  output logic              req_ready,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic [7:0]        in_data,
  output logic              spi_cs_n,
  output logic              spi_tx_valid,
  input  logic              spi_tx_ready,
  output logic [7:0]        spi_tx_byte,
  input  logic [7:0]        spi_rx_byte,
  input  logic [ADDR_W-1:0] cur_addr,
  input  logic              last_in_chunk,
  input  logic              all_done,
  output logic              load,
  output logic              clr_written,
  output logic              chunk_load,
  output logic              byte_fire,
  output logic              chunk_close,
  output logic              done,
  output logic              rejected
);

  localparam int ADDR_BYTES = ADDR_W / 8;
  localparam int IDX_W      = (ADDR_BYTES > 1) ? $clog2(ADDR_BYTES) : 1;

  spf_state_e       state_q, state_d;
  logic             busy_q, busy_d;
  logic [IDX_W-1:0] idx_q, idx_d;
  logic             done_q, done_d;
  logic             rej_q, rej_d;
  logic [7:0]       adr_bytes [ADDR_BYTES];

  // address byte g is bits [8g+7:8g]; sent from the top index down
  for (genvar g = 0; g < ADDR_BYTES; g++) begin : g_adr
    assign adr_bytes[g] = cur_addr[8*g +: 8];
  end

  always_comb begin
    state_d      = state_q;
    busy_d       = busy_q;
    idx_d        = idx_q;
    done_d       = 1'b0;
    rej_d        = 1'b0;
    spi_tx_valid = 1'b0;
    spi_tx_byte  = DUMMY;
    in_ready     = 1'b0;
    load         = 1'b0;
    clr_written  = 1'b0;
    chunk_load   = 1'b0;
    byte_fire    = 1'b0;
    chunk_close  = 1'b0;
    unique case (state_q)
      ST_IDLE: begin
        if (req_valid) begin
          clr_written = 1'b1;
          if (req_zero) begin
            done_d = 1'b1;
          end else if (req_over) begin
            done_d = 1'b1;
            rej_d  = 1'b1;
          end else begin
            load    = 1'b1;
            state_d = ST_POLL_OP;
          end
        end
      end
      ST_POLL_OP: begin
        spi_tx_valid = 1'b1;
        spi_tx_byte  = OP_STATUS;
        if (spi_tx_ready) state_d = ST_POLL_RD;
      end
      ST_POLL_RD: begin
        spi_tx_valid = 1'b1;
        spi_tx_byte  = DUMMY;
        if (spi_tx_ready) begin
          busy_d  = spi_rx_byte[BUSY_BIT];
          state_d = ST_POLL_GAP;
        end
      end
      ST_POLL_GAP: begin
        state_d = busy_q ? ST_POLL_OP : ST_WEN_OP;
      end
      ST_WEN_OP: begin
        spi_tx_valid = 1'b1;
        spi_tx_byte  = OP_WEN;
        if (spi_tx_ready) state_d = ST_WEN_GAP;
      end
      ST_WEN_GAP: begin
        chunk_load = 1'b1;
        state_d    = ST_PRG_OP;
      end
      ST_PRG_OP: begin
        spi_tx_valid = 1'b1;
        spi_tx_byte  = OP_PROG;
        if (spi_tx_ready) begin
          idx_d   = IDX_W'(ADDR_BYTES - 1);
          state_d = ST_PRG_ADR;
        end
      end
      ST_PRG_ADR: begin
        spi_tx_valid = 1'b1;
        spi_tx_byte  = adr_bytes[idx_q];
        if (spi_tx_ready) begin
          if (idx_q == '0) state_d = ST_PRG_DAT;
          else             idx_d   = idx_q - IDX_W'(1);
        end
      end
      ST_PRG_DAT: begin
        spi_tx_valid = in_valid;
        spi_tx_byte  = in_data;
        in_ready     = spi_tx_ready;
        if (in_valid && spi_tx_ready) begin
          byte_fire = 1'b1;
          if (last_in_chunk) state_d = ST_PRG_GAP;
        end
      end
      ST_PRG_GAP: begin
        chunk_close = 1'b1;
        if (all_done) begin
          done_d  = 1'b1;
          state_d = ST_IDLE;
        end else begin
          state_d = ST_POLL_OP;
        end
      end
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      busy_q  <= 1'b0;
      idx_q   <= '0;
      done_q  <= 1'b0;
      rej_q   <= 1'b0;
    end else begin
      state_q <= state_d;
      busy_q  <= busy_d;
      idx_q   <= idx_d;
      done_q  <= done_d;
      rej_q   <= rej_d;
    end
  end

  assign req_ready = (state_q == ST_IDLE);
  assign spi_cs_n  = (state_q == ST_IDLE) || (state_q == ST_POLL_GAP) ||
                     (state_q == ST_WEN_GAP) || (state_q == ST_PRG_GAP);
  assign done      = done_q;
  assign rejected  = rej_q;

  // R4: bytes are offered only inside a select window
  assert_tx_selected_R4: assert property (@(posedge clk) disable iff (!rst_n)
    spi_cs_n |-> !spi_tx_valid)
    else $error("byte offered with select released");

  // R5: payload is taken only while selected and bytes are still owed
  assert_in_ready_data_R5: assert property (@(posedge clk) disable iff (!rst_n)
    in_ready |-> (!spi_cs_n && !all_done))
    else $error("payload taken outside a data phase");

  // R1: the last byte of a chunk ends a page or ends the request
  assert_page_end_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (byte_fire && last_in_chunk) |=> (cur_addr[PAGE_W-1:0] == '0) || all_done)
    else $error("chunk ended inside a page");

  // R9: completion is reported only with the block idle
  assert_done_idle_R9: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> req_ready)
    else $error("done while busy");

  // R7: a refusal always comes with done
  assert_reject_done_R7: assert property (@(posedge clk) disable iff (!rst_n)
    rejected |-> done)
    else $error("rejected without done");

endmodule

// File: rtl/spf_page_writer.sv
module spf_page_writer #(
  parameter int              ADDR_W    = 24,
  parameter int              LEN_W     = 17,
  parameter int              PAGE_W    = 8,
  parameter longint unsigned DEV_BYTES = 64'd1048576
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [LEN_W-1:0]  req_len,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic [7:0]        in_data,
  output logic              spi_cs_n,
  output logic              spi_tx_valid,
  input  logic              spi_tx_ready,
  output logic [7:0]        spi_tx_byte,
  input  logic [7:0]        spi_rx_byte,
  output logic              done,
  output logic              rejected,
  output logic [LEN_W-1:0]  written
);

  logic              req_zero, req_over;
  logic [ADDR_W-1:0] cur_addr;
  logic              last_in_chunk, all_done;
  logic              load, clr_written, chunk_load, byte_fire, chunk_close;

  spf_req_check #(
    .ADDR_W    (ADDR_W),
    .LEN_W     (LEN_W),
    .DEV_BYTES (DEV_BYTES)
  ) u_check (
    .addr    (req_addr),
    .len     (req_len),
    .is_zero (req_zero),
    .is_over (req_over)
  );

  spf_track #(
    .ADDR_W (ADDR_W),
    .LEN_W  (LEN_W),
    .PAGE_W (PAGE_W)
  ) u_track (
    .clk           (clk),
    .rst_n         (rst_n),
    .load          (load),
    .load_addr     (req_addr),
    .load_len      (req_len),
    .clr_written   (clr_written),
    .chunk_load    (chunk_load),
    .byte_fire     (byte_fire),
    .chunk_close   (chunk_close),
    .cur_addr      (cur_addr),
    .last_in_chunk (last_in_chunk),
    .all_done      (all_done),
    .written       (written)
  );

  spf_seq #(
    .ADDR_W (ADDR_W),
    .PAGE_W (PAGE_W)
  ) u_seq (
    .clk           (clk),
    .rst_n         (rst_n),
    .req_valid     (req_valid),
    .req_zero      (req_zero),
    .req_over      (req_over),
    .req_ready     (req_ready),
    .in_valid      (in_valid),
    .in_ready      (in_ready),
    .in_data       (in_data),
    .spi_cs_n      (spi_cs_n),
    .spi_tx_valid  (spi_tx_valid),
    .spi_tx_ready  (spi_tx_ready),
    .spi_tx_byte   (spi_tx_byte),
    .spi_rx_byte   (spi_rx_byte),
    .cur_addr      (cur_addr),
    .last_in_chunk (last_in_chunk),
    .all_done      (all_done),
    .load          (load),
    .clr_written   (clr_written),
    .chunk_load    (chunk_load),
    .byte_fire     (byte_fire),
    .chunk_close   (chunk_close),
    .done          (done),
    .rejected      (rejected)
  );

endmodule

// File: tb/test_spf_page_writer.sv
module test_spf_page_writer;

  localparam int              ADDR_W = 24;
  localparam int              LEN_W  = 17;
  localparam longint unsigned DEV    = 64'd1048576;

  logic              clk = 1'b0;
  logic              rst_n;
  logic              req_valid;
  logic              req_ready;
  logic [ADDR_W-1:0] req_addr;
  logic [LEN_W-1:0]  req_len;
  logic              in_valid;
  logic              in_ready;
  logic [7:0]        in_data;
  logic              spi_cs_n;
  logic              spi_tx_valid;
  logic              spi_tx_ready;
  logic [7:0]        spi_tx_byte;
  logic [7:0]        spi_rx_byte;
  logic              done;
  logic              rejected;
  logic [LEN_W-1:0]  written;

  always #10 clk = ~clk;

  spf_page_writer i_spf_page_writer (
    .clk          (clk),
    .rst_n        (rst_n),
    .req_valid    (req_valid),
    .req_ready    (req_ready),
    .req_addr     (req_addr),
    .req_len      (req_len),
    .in_valid     (in_valid),
    .in_ready     (in_ready),
    .in_data      (in_data),
    .spi_cs_n     (spi_cs_n),
    .spi_tx_valid (spi_tx_valid),
    .spi_tx_ready (spi_tx_ready),
    .spi_tx_byte  (spi_tx_byte),
    .spi_rx_byte  (spi_rx_byte),
    .done         (done),
    .rejected     (rejected),
    .written      (written)
  );

  int n_run = 0;
  int n_fail = 0;

  // reference model state
  logic [7:0]  frame[$];
  int          busy_cnt = 1;
  bit          cs_prev = 1'b1;
  int          phase = 3;       // 0 poll, 1 write-enable, 2 program, 3 none expected
  longint      exp_addr, exp_rem, exp_written;
  int          data_base = 0;
  int          in_idx = 0;
  bit          in_fire_pend = 1'b0;
  int          frame_cnt = 0;
  int          bad_r4 = 0, bad_r5 = 0, bad_r9 = 0;
  bit          done_seen = 1'b0;
  bit          done_rej;
  longint      done_written;
  int          cyc = 0;

  function automatic logic [7:0] pat(int i);
    return 8'((i * 13 + 5) ^ (i >> 8));
  endfunction

  assign in_data     = pat(in_idx);
  assign spi_rx_byte = {6'b101000, 1'b1, (busy_cnt > 0)};

  task automatic check(bit ok, string req, string what, longint act, longint exp);
    n_run++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic end_frame();
    longint chunk;
    int     bad;
    frame_cnt++;
    case (phase)
      0: begin
        check(frame.size() == 2 && frame[0] == 8'h05, "R3", "status frame",
              frame.size() > 0 ? frame[0] : 0, 8'h05);
        check(longint'(written) == exp_written, "R8", "count between chunks",
              written, exp_written);
        if (busy_cnt > 0) busy_cnt--;
        else phase = 1;
      end
      1: begin
        check(frame.size() == 1 && frame[0] == 8'h06, "R3", "write-enable frame",
              frame.size() > 0 ? frame[0] : 0, 8'h06);
        phase = 2;
      end
      2: begin
        chunk = 256 - (exp_addr % 256);
        if (exp_rem < chunk) chunk = exp_rem;
        check(frame.size() == 4 + chunk, "R1", "program frame length",
              frame.size(), 4 + chunk);
        if (frame.size() >= 4)
          check(frame[0] == 8'h02 && frame[1] == 8'(exp_addr >> 16) &&
                frame[2] == 8'(exp_addr >> 8) && frame[3] == 8'(exp_addr),
                "R2", "program header",
                {frame[0], frame[1], frame[2], frame[3]},
                {8'h02, 8'(exp_addr >> 16), 8'(exp_addr >> 8), 8'(exp_addr)});
        bad = 0;
        for (int i = 0; i < chunk && 4 + i < frame.size(); i++)
          if (frame[4 + i] != pat(data_base + i)) bad++;
        check(bad == 0, "R2", "program payload mismatches", bad, 0);
        data_base   += int'(chunk);
        exp_addr    += chunk;
        exp_rem     -= chunk;
        exp_written += chunk;
        busy_cnt     = 2;
        phase        = (exp_rem == 0) ? 3 : 0;
      end
      default: check(1'b0, "R4", "unexpected frame", frame.size(), 0);
    endcase
    frame.delete();
  endtask

  // sampling, away from the active edge
  always @(negedge clk) begin
    if (rst_n) begin
      if (spi_cs_n && spi_tx_valid) bad_r4++;
      if (in_ready && !(!spi_cs_n && frame.size() >= 4 && frame[0] == 8'h02)) bad_r5++;
      if (req_ready && phase != 3) bad_r9++;
      if (!spi_cs_n && spi_tx_valid && spi_tx_ready) frame.push_back(spi_tx_byte);
      if (in_valid && in_ready) in_fire_pend = 1'b1;
      if (spi_cs_n && !cs_prev) end_frame();
      cs_prev = spi_cs_n;
      if (done) begin
        done_seen    = 1'b1;
        done_rej     = rejected;
        done_written = longint'(written);
      end
    end
  end

  // input driving, shortly after the active edge
  always @(posedge clk) begin
    #2;
    cyc++;
    spi_tx_ready = (cyc % 5) != 3;
    in_valid     = (cyc % 7) != 2;
    if (in_fire_pend) begin
      in_idx++;
      in_fire_pend = 1'b0;
    end
  end

  task automatic finish_run();
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  endtask

  always @(posedge clk) begin
    if (cyc > 150000) begin
      n_run++;
      n_fail++;
      $display("FAIL watchdog: actual %0d cycles expected below 150000", cyc);
      finish_run();
    end
  end

  // kind: 0 normal, 1 empty, 2 refused
  task automatic run_req(longint addr, longint len, int kind);
    int w;
    @(posedge clk);
    #3;
    req_addr    = ADDR_W'(addr);
    req_len     = LEN_W'(len);
    req_valid   = 1'b1;
    done_seen   = 1'b0;
    frame_cnt   = 0;
    data_base   = in_idx;
    exp_addr    = addr;
    exp_rem     = len;
    exp_written = 0;
    @(posedge clk);
    #3;
    req_valid = 1'b0;
    if (kind == 0) phase = 0;
    @(negedge clk);
    #1;
    if (kind == 1) begin
      check(done_seen && !done_rej && done_written == 0, "R6",
            "empty request completion", {done_seen, done_rej}, 2'b10);
    end else if (kind == 2) begin
      check(done_seen && done_rej && done_written == 0, "R7",
            "refusal", {done_seen, done_rej}, 2'b11);
    end
    if (kind != 0) begin
      repeat (20) @(negedge clk);
      #1;
      check(frame_cnt == 0 && frame.size() == 0, kind == 1 ? "R6" : "R7",
            "bus traffic on a request without work", frame_cnt, 0);
    end else begin
      w = 0;
      while (!done_seen && w < 20000) begin
        @(negedge clk);
        #1;
        w++;
      end
      check(done_seen && !done_rej, "R7", "accepted request finished",
            {done_seen, done_rej}, 2'b10);
      check(done_written == len, "R8", "count at done", done_written, len);
      check(phase == 3 && exp_rem == 0, "R9", "done after final chunk", exp_rem, 0);
      @(negedge clk);
      #1;
      check(!done, "R9", "done pulse width", done, 0);
    end
    check(bad_r4 == 0, "R4", "bytes offered with select high", bad_r4, 0);
    check(bad_r5 == 0, "R5", "payload taken outside data phase", bad_r5, 0);
    check(bad_r9 == 0, "R9", "ready while busy", bad_r9, 0);
    bad_r4 = 0;
    bad_r5 = 0;
    bad_r9 = 0;
  endtask

  initial begin
    rst_n        = 1'b0;
    req_valid    = 1'b0;
    req_addr     = '0;
    req_len      = '0;
    in_valid     = 1'b0;
    spi_tx_ready = 1'b0;
    repeat (3) @(posedge clk);
    #3;
    rst_n = 1'b1;
    @(negedge clk);
    #1;
    check(req_ready && spi_cs_n && !done && !in_ready && written == 0, "R9",
          "reset state", {req_ready, spi_cs_n, done, in_ready}, 4'b1100);

    run_req(64'h000010, 20, 0);    // inside one page (R1)
    run_req(64'h0000F0, 40, 0);    // crosses one boundary: 16 + 24 (R1)
    run_req(64'h000100, 256, 0);   // exactly one aligned page (R1)
    run_req(64'h0012FF, 300, 0);   // 1 + 256 + 43 (R1, R2)
    run_req(64'h0001FF, 1, 0);     // single byte at page end (R1)
    run_req(DEV + 5, 0, 1);        // empty, address beyond device (R6)
    run_req(DEV - 10, 11, 2);      // one byte past the end (R7)
    run_req(DEV - 10, 10, 0);      // ends exactly at the end (R7)
    run_req(64'h000000, 0, 1);     // empty at zero (R6)

    finish_run();
  end

endmodule